// File: doc/BRIEF.md
# Distribution-Register Accumulator Datapath

This block is the register-and-adder core of a small word-oriented processor. It holds three registers. The accumulator A is always visible on the output bus. The distribution register D is the hub for moving words between registers and is the only entry point for the input bus. The memory buffer M is the only path towards memory.

A single sum network adds a left operand and a right operand. The left operand is A or D. The right operand is M or the inverse of M. Subtraction is done by adding the inverse of M with a carry-in of one.

An external sequencer drives a set of independent strobes each cycle. Operand-select strobes choose what enters the sum network. Load strobes choose which registers capture on the rising edge, and what they capture. Results can go back into A unchanged, shifted right arithmetically, or shifted left with a zero fill. They can go into D. They can go into M either directly or through D on a later cycle.

Top module: `dflow_datapath`

## Requirements
- R1: While `rst_n` is low, A, D and M are cleared to zero, and they read zero after reset is released.
- R2: The sum is (left + right + cin) modulo 2^W. Left is A when `sel_a` is high, otherwise D when `sel_d` is high, otherwise 0. Right is ~M when `sel_neg` is high, otherwise M when `sel_m` is high, otherwise 0. `cin` is 1 exactly when `sel_neg` is high.
- R3: `carry_out` is the carry out of bit W-1 of that addition. `ovf_out` is high exactly when the two's-complement result lies outside the signed W-bit range.
- R4: `ld_in_d` loads `in_bus` into D at the next rising edge. It has priority over `ld_sum_d`, which loads the sum into D.
- R5: `ld_sum_m` loads the sum straight into M. `ld_d_m` loads D into M. When both are high, the sum wins.
- R6: `ld_sum_a` loads the unshifted sum into A.
- R7: `shr_a` loads the sum shifted right by one into A, with the sign bit replicated. `shl_a` loads the sum shifted left by one into A, with a zero in bit 0. Priority for A is `shr_a`, then `shl_a`, then `ld_sum_a`.
- R8: `out_bus` always equals A, with no enable.
- R9: A register whose load strobes are all low keeps its value, even while operand-select strobes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| in_bus | input | W | External input word |
| sel_a | input | 1 | A onto left sum input |
| sel_d | input | 1 | D onto left sum input (if sel_a low) |
| sel_m | input | 1 | M onto right sum input |
| sel_neg | input | 1 | ~M onto right sum input, carry-in 1 |
| ld_in_d | input | 1 | Load input bus into D |
| ld_sum_d | input | 1 | Load sum into D |
| ld_sum_m | input | 1 | Load sum into M |
| ld_d_m | input | 1 | Load D into M |
| ld_sum_a | input | 1 | Load sum into A |
| shr_a | input | 1 | Load arithmetic right shift of sum into A |
| shl_a | input | 1 | Load left shift of sum into A |
| out_bus | output | W | Output bus, always A |
| d_out | output | W | Current D |
| m_out | output | W | Current M, towards memory |
| sum_out | output | W | Sum network result |
| carry_out | output | 1 | Carry out of the sum |
| ovf_out | output | 1 | Signed overflow of the sum |

## Verification
The bench uses a 4-bit word and sweeps every pair of A and M values through four operations: addition, subtraction through the negated path, D plus M, and both shifts into A. Addition and subtraction separate the carry-in and inversion handling. Corner pairs such as 7+1 and -8-1 separate carry from signed overflow. The shifts show sign replication versus zero fill. Short directed sequences check strobe priorities and register hold with no load strobe, observed through `out_bus`, `d_out` and `m_out`.

// File: rtl/dflow_datapath.sv
module dflow_datapath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_bus,
  input  logic         sel_a,
  input  logic         sel_d,
  input  logic         sel_m,
  input  logic         sel_neg,
  input  logic         ld_in_d,
  input  logic         ld_sum_d,
  input  logic         ld_sum_m,
  input  logic         ld_d_m,
  input  logic         ld_sum_a,
  input  logic         shr_a,
  input  logic         shl_a,
  output logic [W-1:0] out_bus,
  output logic [W-1:0] d_out,
  output logic [W-1:0] m_out,
  output logic [W-1:0] sum_out,
  output logic         carry_out,
  output logic         ovf_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_q, d_q, m_q;
  logic [W-1:0] left_op, right_op;
  logic         cin;
  logic [W:0]   full_sum;

  assign left_op  = sel_a ? a_q : (sel_d ? d_q : '0);
  assign right_op = sel_neg ? ~m_q : (sel_m ? m_q : '0);
  assign cin      = sel_neg;
  assign full_sum = {1'b0, left_op} + {1'b0, right_op} + {{W{1'b0}}, cin};

  assign sum_out   = full_sum[MSB:0];
  assign carry_out = full_sum[W];
  assign ovf_out   = (left_op[MSB] == right_op[MSB]) && (sum_out[MSB] != left_op[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      d_q <= '0;
      m_q <= '0;
    end else begin
      if (shr_a)         a_q <= {sum_out[MSB], sum_out[MSB:1]};
      else if (shl_a)    a_q <= {sum_out[MSB-1:0], 1'b0};
      else if (ld_sum_a) a_q <= sum_out;

      if (ld_in_d)       d_q <= in_bus;
      else if (ld_sum_d) d_q <= sum_out;

      if (ld_sum_m)      m_q <= sum_out;
      else if (ld_d_m)   m_q <= d_q;
    end
  end

  assign out_bus = a_q;
  assign d_out   = d_q;
  assign m_out   = m_q;

  p_in_to_d_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_in_d |=> d_out == $past(in_bus));

  p_sum_to_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sum_m |=> m_out == $past(sum_out));

  p_shr_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shr_a |=> out_bus[MSB] == $past(sum_out[MSB]));

  p_shl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_a && !shr_a) |=> out_bus[0] == 1'b0);

  p_hold_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(shr_a || shl_a || ld_sum_a) |=> $stable(out_bus));

  p_hold_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_sum_m || ld_d_m) |=> $stable(m_out));
endmodule

// File: tb/dflow_datapath_bench.sv
module dflow_datapath_bench;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] in_bus = '0;
  logic sel_a = 0, sel_d = 0, sel_m = 0, sel_neg = 0;
  logic ld_in_d = 0, ld_sum_d = 0, ld_sum_m = 0, ld_d_m = 0;
  logic ld_sum_a = 0, shr_a = 0, shl_a = 0;
  logic [W-1:0] out_bus, d_out, m_out, sum_out;
  logic carry_out, ovf_out;

  int checks = 0, fails = 0;
  bit done = 0;

  dflow_datapath #(.W(W)) u_dflow_datapath (
    .clk(clk), .rst_n(rst_n), .in_bus(in_bus),
    .sel_a(sel_a), .sel_d(sel_d), .sel_m(sel_m), .sel_neg(sel_neg),
    .ld_in_d(ld_in_d), .ld_sum_d(ld_sum_d), .ld_sum_m(ld_sum_m), .ld_d_m(ld_d_m),
    .ld_sum_a(ld_sum_a), .shr_a(shr_a), .shl_a(shl_a),
    .out_bus(out_bus), .d_out(d_out), .m_out(m_out), .sum_out(sum_out),
    .carry_out(carry_out), .ovf_out(ovf_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    {sel_a, sel_d, sel_m, sel_neg} = '0;
    {ld_in_d, ld_sum_d, ld_sum_m, ld_d_m, ld_sum_a, shr_a, shl_a} = '0;
  endtask

  task automatic load_a(input int v);
    idle(); in_bus = W'(v); ld_in_d = 1; step();
    idle(); sel_d = 1; ld_sum_a = 1; step(); idle();
  endtask

  task automatic load_m(input int v);
    idle(); in_bus = W'(v); ld_in_d = 1; step();
    idle(); ld_d_m = 1; step(); idle();
  endtask

  function automatic int sx(input int v);
    return ((v & MASK) >= (1 << (W-1))) ? (v & MASK) - (1 << W) : (v & MASK);
  endfunction

  task automatic check_sum(input string req, input int l, input int r, input int c);
    int raw = (l & MASK) + (r & MASK) + c;
    int s = sx(l) + sx(r) + c;
    int ov = (s > (1 << (W-1)) - 1 || s < -(1 << (W-1))) ? 1 : 0;
    chk(req, sum_out, raw & MASK);
    chk({req, " carry R3"}, carry_out, (raw >> W) & 1);
    chk({req, " ovf R3"}, ovf_out, ov);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    chk("R1 A", out_bus, 0); chk("R1 D", d_out, 0); chk("R1 M", m_out, 0);
    rst_n = 1;
    step();
    chk("R1 A after", out_bus, 0); chk("R1 M after", m_out, 0);

    for (int a = 0; a <= MASK; a++) begin
      for (int m = 0; m <= MASK; m++) begin
        load_a(a); load_m(m);
        chk("R8 out_bus", out_bus, a);
        chk("R5 D to M", m_out, m);
        sel_a = 1; sel_m = 1; #1;
        check_sum("R2 add", a, m, 0);
        idle(); sel_a = 1; sel_neg = 1; #1;
        check_sum("R2 sub", a, (~m) & MASK, 1);
        idle(); sel_d = 1; sel_m = 1; #1;
        check_sum("R2 D+M", m, m, 0);
        idle(); sel_a = 1; sel_neg = 1; sel_m = 1; #1;
        check_sum("R2 neg priority", a, (~m) & MASK, 1);
        idle(); #1;
        chk("R2 zero operands", sum_out, 0);
        sel_a = 1; sel_m = 1; shr_a = 1; step(); idle();
        chk("R7 shr", out_bus, (sx(a + m) >>> 1) & MASK);
        load_a(a);
        sel_a = 1; sel_m = 1; shl_a = 1; step(); idle();
        chk("R7 shl", out_bus, ((a + m) << 1) & MASK);
        load_a(a);
        sel_a = 1; sel_m = 1; ld_sum_a = 1; step(); idle();
        chk("R6 sum to A", out_bus, (a + m) & MASK);
      end
    end

    load_a(5); load_m(3);
    sel_a = 1; sel_m = 1; in_bus = 4'd9; ld_in_d = 1; ld_sum_d = 1; step(); idle();
    chk("R4 in over sum", d_out, 9);
    sel_a = 1; sel_m = 1; ld_sum_d = 1; step(); idle();
    chk("R4 sum to D", d_out, 8);
    in_bus = 4'd1; ld_in_d = 1; step(); idle();
    sel_a = 1; sel_m = 1; ld_sum_m = 1; ld_d_m = 1; step(); idle();
    chk("R5 sum over D", m_out, 8);
    load_a(5); load_m(6);
    sel_a = 1; sel_m = 1; shr_a = 1; shl_a = 1; ld_sum_a = 1; step(); idle();
    chk("R7 shr priority", out_bus, 4'hD);
    load_a(5); load_m(6);
    sel_a = 1; sel_m = 1; shl_a = 1; ld_sum_a = 1; step(); idle();
    chk("R7 shl over load", out_bus, 4'h6);
    load_a(7); load_m(2);
    sel_a = 1; sel_neg = 1; in_bus = 4'hF; step(); step(); idle();
    chk("R9 A hold", out_bus, 7); chk("R9 D hold", d_out, 2); chk("R9 M hold", m_out, 2);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule